// File: doc/BRIEF.md
# Burst-of-Two Double-Data-Rate SRAM Model

This block is a synthesizable, cycle-exact model of a synchronous common-I/O SRAM. Its interface moves two data beats per command, one in each half of the clock. The host sets up a command on each rising edge of `clk`. A command is the load strobe, the read/write select and a pair address. The low phase of `clk` stands in for the complementary clock K#, so the first half-beat of a transfer falls on the falling edge of `clk` and the second on the next rising edge. New commands may be issued on every cycle with no gap.

Each internal access is two bus-widths wide. On a write, the two incoming beats are collected, merged under per-beat byte enables with the word already stored, and committed to the array in a single access. On a read, a single array access is split across the two output beats. Read data reaches the bus after two full clock periods, and a valid flag travels with it. The shared bus is modelled as a split input and output. A drive-enable port marks the read beats; everywhere else the bus is released.

Top module: `sdr2b_sram`

## Requirements
- R1: A command is taken on a rising edge of `clk`. If `ldN`=0 and `rwSel`=1 it is a read. If `ldN`=0 and `rwSel`=0 it is a write. If `ldN`=1 it is a deselect. A write or a deselect never produces read beats.
- R2: An address selects a two-beat pair. For a write captured on edge E, the bench drives beat 0 for the falling edge after E and beat 1 for the next rising edge. Beat 0 is stored in bits [BUS_W-1:0] of the array word and beat 1 in the upper half, and a later read returns them in the same order.
- R3: `bwN` is active low, one bit per 9-bit lane. Lane n covers bus bits 9n to 9n+8. It is sampled with each beat separately. A lane whose enable is 1 keeps its stored bits, including when every lane of both beats is disabled.
- R4: For a read captured on rising edge E, beat 0 is on `dqOut` while `clk` is high after rising edge E+2. Beat 1 follows during the low phase after it.
- R5: `readValid` is 1 during exactly the half-cycles that carry read beats and 0 otherwise.
- R6: `dqDrive` is 1 only during read beats. A deselect or write issued right after a read lets both read beats complete, then the bus is released.
- R7: A read captured on the cycle right after a write to the same address returns the newly written data.
- R8: Commands may be accepted on every rising edge. Back-to-back reads produce an unbroken stream of beats.
- R9: While `rstN` is low, no read beat is pending, and `readValid` and `dqDrive` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Primary clock; its low phase acts as the complementary clock |
| rstN | input | 1 | Synchronous active-low reset of the command pipeline |
| ldN | input | 1 | Active-low load strobe; high means deselect |
| rwSel | input | 1 | Read (1) or write (0) select |
| addr | input | ADDR_W | Pair address |
| dqIn | input | LANES*LANE_W | Data bus as seen entering the device |
| bwN | input | LANES | Active-low byte-lane write enables, one per beat |
| dqOut | output | LANES*LANE_W | Data bus as driven by the device |
| dqDrive | output | 1 | High while the device drives the bus |
| readValid | output | 1 | High during beats that carry read data |

## Verification
Some properties are checked by assertions on every cycle. After a read command, the valid flag must appear exactly three sampled edges later. After a non-read command, it must stay low at that point. A commit with every lane disabled must leave the stored word untouched, and a fully enabled commit must store both gathered beats. Other behaviour only shows up in the bench's sweeps. These cover the beat order of the returned data, the merging of mixed lane masks, coherence when a read directly follows a write to the same address, and the exact half-cycle placement of the drive window around deselects.

// File: rtl/sdr2b_pkg.sv
package sdr2b_pkg;
  // Strobes from the command pipeline into the datapath
  typedef struct packed {
    logic writeBeats;   // a write is collecting its beats this cycle
    logic loadRead;     // the read in the last pipeline stage loads its word
  } ctlStrobes_t;
endpackage

// File: rtl/sdr2b_ctrl.sv
module sdr2b_ctrl
  import sdr2b_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ldN,
  input  logic              rwSel,
  input  logic [ADDR_W-1:0] addr,
  output ctlStrobes_t       strobes,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              outValid
);
  localparam int RD_STAGES = 2;

  logic cmdRead, cmdWrite;
  logic wrPend;
  logic [RD_STAGES-1:0] rdPipe;
  logic [ADDR_W-1:0] rdAddrPipe [RD_STAGES];

  assign cmdRead  = !ldN && rwSel;
  assign cmdWrite = !ldN && !rwSel;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPend   <= 1'b0;
      rdPipe   <= '0;
      outValid <= 1'b0;
    end else begin
      wrPend   <= cmdWrite;
      rdPipe   <= {rdPipe[RD_STAGES-2:0], cmdRead};
      outValid <= rdPipe[RD_STAGES-1];
    end
  end

  always_ff @(posedge clk) begin
    wrAddr        <= addr;
    rdAddrPipe[0] <= addr;
  end

  for (genvar st = 1; st < RD_STAGES; st++) begin : gRdStage
    always_ff @(posedge clk) rdAddrPipe[st] <= rdAddrPipe[st-1];
  end

  assign rdAddr             = rdAddrPipe[RD_STAGES-1];
  assign strobes.writeBeats = wrPend;
  assign strobes.loadRead   = rdPipe[RD_STAGES-1];

  // R4: a captured read shows valid three sampled edges later
  assert_read_latency_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!ldN && rwSel) |-> ##3 outValid);

  // R6: any non-read command leaves the bus idle in its slot
  assert_idle_after_nonread_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(!ldN && rwSel) |-> ##3 !outValid);
endmodule

// File: rtl/sdr2b_datapath.sv
module sdr2b_datapath
  import sdr2b_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int LANE_W = 9,
  parameter int LANES  = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  ctlStrobes_t               strobes,
  input  logic [ADDR_W-1:0]         wrAddr,
  input  logic [ADDR_W-1:0]         rdAddr,
  input  logic                      outValid,
  input  logic [LANES*LANE_W-1:0]   dqIn,
  input  logic [LANES-1:0]          bwN,
  output logic [LANES*LANE_W-1:0]   dqOut,
  output logic                      dqDrive,
  output logic                      readValid
);
  localparam int BUS_W  = LANES * LANE_W;
  localparam int WORD_W = 2 * BUS_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [BUS_W-1:0]  beat0Q;
  logic [LANES-1:0]  bw0Q;
  logic [WORD_W-1:0] oldWord, mergedWord, outWord;

  // First beat lands on the falling edge (complementary clock rise)
  always_ff @(negedge clk) begin
    if (strobes.writeBeats) begin
      beat0Q <= dqIn;
      bw0Q   <= bwN;
    end
  end

  assign oldWord = mem[wrAddr];

  for (genvar g = 0; g < LANES; g++) begin : gLane
    assign mergedWord[g*LANE_W +: LANE_W] =
      bw0Q[g] ? oldWord[g*LANE_W +: LANE_W] : beat0Q[g*LANE_W +: LANE_W];
    assign mergedWord[BUS_W + g*LANE_W +: LANE_W] =
      bwN[g] ? oldWord[BUS_W + g*LANE_W +: LANE_W] : dqIn[g*LANE_W +: LANE_W];
  end

  // Second beat arrives on this rising edge; commit the whole pair
  always_ff @(posedge clk) begin
    if (strobes.writeBeats) mem[wrAddr] <= mergedWord;
    if (strobes.loadRead)   outWord     <= mem[rdAddr];
  end

  // Phase mux: low half while clk high, upper half while clk low
  assign dqOut     = !outValid ? '0 : (clk ? outWord[BUS_W-1:0] : outWord[WORD_W-1:BUS_W]);
  assign dqDrive   = outValid;
  assign readValid = outValid;

  // R3: a commit with every lane disabled leaves the word unchanged
  assert_masked_commit_holds_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.writeBeats && (&bw0Q) && (&bwN)) |=> mem[$past(wrAddr)] == $past(mem[wrAddr]));

  // R2: a fully enabled commit stores beat 0 low and beat 1 high
  assert_full_commit_order_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.writeBeats && bw0Q == '0 && bwN == '0) |=> mem[$past(wrAddr)] == $past({dqIn, beat0Q}));
endmodule

// File: rtl/sdr2b_sram.sv
module sdr2b_sram
  import sdr2b_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int LANE_W = 9,
  parameter int LANES  = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    ldN,
  input  logic                    rwSel,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] dqIn,
  input  logic [LANES-1:0]        bwN,
  output logic [LANES*LANE_W-1:0] dqOut,
  output logic                    dqDrive,
  output logic                    readValid
);
  ctlStrobes_t       strobes;
  logic [ADDR_W-1:0] wrAddr, rdAddr;
  logic              outValid;

  sdr2b_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .ldN(ldN), .rwSel(rwSel), .addr(addr),
    .strobes(strobes), .wrAddr(wrAddr), .rdAddr(rdAddr), .outValid(outValid)
  );

  sdr2b_datapath #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_datapath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .outValid(outValid), .dqIn(dqIn), .bwN(bwN), .dqOut(dqOut),
    .dqDrive(dqDrive), .readValid(readValid)
  );
endmodule

// File: tb/sdr2b_sram_bench.sv
module sdr2b_sram_bench;
  localparam int AW = 4, LW = 9, LN = 4, BW = LW * LN, DEPTH = 1 << AW, NCMD = 120;

  logic clk = 1'b0, rstN = 1'b0, ldN = 1'b1, rwSel = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [BW-1:0] dqIn = '0;
  logic [LN-1:0] bwN = '1;
  logic [BW-1:0] dqOut;
  logic dqDrive, readValid;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [2*BW-1:0] refMem [DEPTH];

  sdr2b_sram #(.ADDR_W(AW), .LANE_W(LW), .LANES(LN)) u_sdr2b_sram (
    .clk(clk), .rstN(rstN), .ldN(ldN), .rwSel(rwSel), .addr(addr),
    .dqIn(dqIn), .bwN(bwN), .dqOut(dqOut), .dqDrive(dqDrive), .readValid(readValid)
  );

  always #10 clk = ~clk;   // 50 MHz

  // 0 deselect, 1 read, 2 write
  function automatic int kindOf(int i);
    if (i < 0 || i >= NCMD) return 0;
    if (i < 16) return 2;
    if (i < 32) return 1;
    if (i < 64) return (i % 2 == 0) ? 2 : 1;
    if (i < 96) return (i % 4 == 3) ? 0 : 2;
    return (i % 3 == 2) ? 0 : 1;
  endfunction

  function automatic logic [AW-1:0] addrOf(int i);
    if (i < 16) return AW'(i);
    if (i < 32) return AW'(i - 16);
    if (i < 64) return AW'(((i - 32) / 2) * 7);
    if (i < 96) return AW'(i * 5);
    return AW'(i * 3);
  endfunction

  function automatic logic [BW-1:0] beatData(int i, int k);
    return BW'((i + 1) * 36'h1_0203_0405 + k * 36'h7_7777_7777);
  endfunction

  function automatic logic [LN-1:0] beatMask(int i, int k);
    if (i < 64) return '0;
    if (i == 90) return '1;
    return (k == 0) ? LN'(i) : LN'(i * 7);
  endfunction

  function automatic logic [BW-1:0] mergeBeat(logic [BW-1:0] old, logic [BW-1:0] d, logic [LN-1:0] m);
    logic [BW-1:0] r;
    r = old;
    for (int l = 0; l < LN; l++) if (!m[l]) r[l*LW +: LW] = d[l*LW +: LW];
    return r;
  endfunction

  function automatic string tagOf(int j);
    if (j < 16) return "R4/R2";
    if (j < 32) return "R4/R8/R2";
    if (j < 64) return "R7";
    return "R3";
  endfunction

  task automatic check(string req, logic [2*BW-1:0] act, logic [2*BW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic sampleBeat(int j, logic [BW-1:0] expBeat);
    if (kindOf(j) == 1) begin
      check(tagOf(j), 72'(dqOut), 72'(expBeat));
      check("R5", 72'(readValid), 72'(1));
      check("R6", 72'(dqDrive), 72'(1));
    end else begin
      check((kindOf(j) == 2) ? "R1" : "R6", 72'(dqDrive), 72'(0));
      check("R5", 72'(readValid), 72'(0));
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #3;
    check("R9", 72'(dqDrive), 72'(0));
    check("R9", 72'(readValid), 72'(0));
    rstN = 1'b1;
    for (int s = 0; s < NCMD + 4; s++) begin
      logic [2*BW-1:0] expWord;
      @(posedge clk);
      #3;
      expWord = '0;
      if (kindOf(s - 3) == 1) expWord = refMem[addrOf(s - 3)];
      if (kindOf(s - 2) == 2) begin
        logic [AW-1:0] a;
        a = addrOf(s - 2);
        refMem[a] = {mergeBeat(refMem[a][2*BW-1:BW], beatData(s - 2, 1), beatMask(s - 2, 1)),
                     mergeBeat(refMem[a][BW-1:0],    beatData(s - 2, 0), beatMask(s - 2, 0))};
      end
      ldN   = (kindOf(s) == 0);
      rwSel = (kindOf(s) == 1);
      addr  = addrOf(s);
      if (kindOf(s - 1) == 2) begin
        dqIn = beatData(s - 1, 0);
        bwN  = beatMask(s - 1, 0);
      end else begin
        dqIn = BW'(36'h5_A5A5_A5A5 ^ s);
        bwN  = '0;
      end
      sampleBeat(s - 3, expWord[BW-1:0]);
      #10;
      if (kindOf(s - 1) == 2) begin
        dqIn = beatData(s - 1, 1);
        bwN  = beatMask(s - 1, 1);
      end else begin
        dqIn = BW'(36'hA_5A5A_5A5A ^ s);
        bwN  = '0;
      end
      sampleBeat(s - 3, expWord[2*BW-1:BW]);
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule